// File: doc/BRIEF.md
# Byte-Lane Data Mask Unit

This block sits between the data pins and the storage array of a 32-bit synchronous memory. It applies byte masks to both directions of the data path. There is one active-high mask input for each byte lane, and the rising clock edge samples it. In a write cycle of a burst, a sampled mask removes the byte-enable of its lane in that same cycle, so the array does not store that byte. In a read cycle, the sampled mask travels down a short per-lane pipeline and turns off that lane's output two clocks later. A disabled lane drives either zero or high impedance, chosen by a parameter, and raises an active-low valid flag.

The block also holds the burst column address. A start strobe loads the column address. After that, each active burst cycle advances the column address within an aligned window whose size is the burst length. The mask inputs never hold this counter back. The surrounding controller sees the write enables, the gated read data, the per-lane drive status and the current column.

Top module: `bmask_unit`

## Requirements
- R1: Mask bit i governs data bits 8i+7 down to 8i: bit 0 covers 7:0, bit 1 covers 15:8, bit 2 covers 23:16 and bit 3 covers 31:24.
- R2: `wr_be_o[i]` is high only when `burst_active_i` is high, `burst_wr_i` is high and `lane_mask_i[i]` is low. This is combinational, so it holds in the same cycle in which the mask is sampled.
- R3: `wr_data_o` equals `wr_data_i` with the same polarity, whatever the masks are.
- R4: A mask bit sampled high at rising edge k, in a cycle where `burst_active_i` is high and `burst_wr_i` is low, drives `rd_oe_o[i]` low for exactly one cycle. That cycle runs from edge k+1 to edge k+2.
- R5: Mask bits sampled in write cycles or in idle cycles (`burst_active_i` low) never reach the read side. `rd_oe_o` stays all ones two cycles later.
- R6: When the parameter `HIZ_MODE` is `MASK_ZERO` (the default), a lane with `rd_oe_o[i]` low outputs zero. When it is `MASK_HIZ`, such a lane outputs high impedance. A lane with `rd_oe_o[i]` high passes `rd_data_i` through unchanged.
- R7: `rd_vld_n_o[i]` is high exactly when `rd_oe_o[i]` is low.
- R8: A rising edge with `burst_start_i` high loads `start_col_i` into `col_addr_o`. A rising edge with `burst_active_i` high and no start adds one to the low log2(BURST_LEN) bits of `col_addr_o`, wrapping to zero at the window end, and keeps the upper bits. The lane masks have no effect on this counter.
- R9: While `rst_ni` is low and in the first cycle after it rises, `rd_oe_o` is all ones and `col_addr_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| burst_active_i | input | 1 | Current cycle is a burst data cycle |
| burst_wr_i | input | 1 | Burst direction: 1 write, 0 read |
| burst_start_i | input | 1 | Load the column counter |
| start_col_i | input | 9 | Starting column address |
| lane_mask_i | input | 4 | Per-lane mask, active high |
| wr_data_i | input | 32 | Write data from the pins |
| rd_data_i | input | 32 | Read data from the array |
| wr_data_o | output | 32 | Write data toward the array |
| wr_be_o | output | 4 | Per-lane write byte-enable |
| rd_data_o | output | 32 | Gated read data toward the pins |
| rd_oe_o | output | 4 | Per-lane output drive enable |
| rd_vld_n_o | output | 4 | Per-lane valid flag, active low |
| col_addr_o | output | 9 | Current burst column address |

## Verification
The assertions assume that the inputs are steady at every rising edge and that reset is low at time zero. The read-delay property is checked only after two edges have passed out of reset. The stimulus changes every input on the falling edge and samples the outputs on the falling edge, so each rising edge sees settled values. It holds `burst_start_i` low during counting runs, so each load and each increment can be told apart.

// File: rtl/bmask_pkg.sv
package bmask_pkg;

    // Value driven on a read lane whose output is disabled
    typedef enum logic {
        MASK_ZERO = 1'b0,
        MASK_HIZ  = 1'b1
    } hiz_mode_e;

endpackage

// File: rtl/bmask_rd_pipe.sv
// Two-stage per-lane delay of the read mask; stage 2 drives output enable low.
module bmask_rd_pipe #(
    parameter int LANES = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             capture_i,
    input  logic [LANES-1:0] mask_i,
    output logic [LANES-1:0] oe_o
);

    typedef struct packed {
        logic [LANES-1:0] stg1;
        logic [LANES-1:0] stg2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    always_comb begin
        pipe_d      = pipe_q;
        pipe_d.stg1 = capture_i ? mask_i : '0;
        pipe_d.stg2 = pipe_q.stg1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign oe_o = ~pipe_q.stg2;

endmodule

// File: rtl/bmask_rd_drive.sv
// Per-lane read output gating; zero or high impedance chosen by parameter.
module bmask_rd_drive
    import bmask_pkg::*;
#(
    parameter int        LANES    = 4,
    parameter int        LANE_W   = 8,
    parameter hiz_mode_e HIZ_MODE = MASK_ZERO,
    localparam int       DATA_W   = LANES * LANE_W
) (
    input  logic [DATA_W-1:0] rd_data_i,
    input  logic [LANES-1:0]  oe_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [LANES-1:0]  vld_n_o
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        if (HIZ_MODE == MASK_HIZ) begin : g_hiz
            assign rd_data_o[g*LANE_W +: LANE_W] =
                oe_i[g] ? rd_data_i[g*LANE_W +: LANE_W] : {LANE_W{1'bz}};
        end else begin : g_zero
            assign rd_data_o[g*LANE_W +: LANE_W] =
                oe_i[g] ? rd_data_i[g*LANE_W +: LANE_W] : '0;
        end
        assign vld_n_o[g] = ~oe_i[g];
    end

endmodule

// File: rtl/bmask_col_ctr.sv
// Burst column counter; wraps within an aligned window of BURST_LEN columns.
module bmask_col_ctr #(
    parameter int COL_W     = 9,
    parameter int BURST_LEN = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             load_i,
    input  logic [COL_W-1:0] load_col_i,
    input  logic             step_i,
    output logic [COL_W-1:0] col_o
);

    localparam logic [COL_W-1:0] WRAP_MASK = COL_W'(BURST_LEN - 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
    } ctr_t;

    ctr_t ctr_d, ctr_q;
    logic [COL_W-1:0] col_inc;

    always_comb begin
        col_inc = ctr_q.col + COL_W'(1);
        ctr_d   = ctr_q;
        if (load_i) begin
            ctr_d.col = load_col_i;
        end else if (step_i) begin
            ctr_d.col = (ctr_q.col & ~WRAP_MASK) | (col_inc & WRAP_MASK);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign col_o = ctr_q.col;

endmodule

// File: rtl/bmask_unit.sv
module bmask_unit
    import bmask_pkg::*;
#(
    parameter int        LANES     = 4,
    parameter int        LANE_W    = 8,
    parameter int        COL_W     = 9,
    parameter int        BURST_LEN = 8,
    parameter hiz_mode_e HIZ_MODE  = MASK_ZERO,
    localparam int       DATA_W    = LANES * LANE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              burst_active_i,
    input  logic              burst_wr_i,
    input  logic              burst_start_i,
    input  logic [COL_W-1:0]  start_col_i,
    input  logic [LANES-1:0]  lane_mask_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic [DATA_W-1:0] wr_data_o,
    output logic [LANES-1:0]  wr_be_o,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [LANES-1:0]  rd_oe_o,
    output logic [LANES-1:0]  rd_vld_n_o,
    output logic [COL_W-1:0]  col_addr_o
);

    logic wr_cycle;
    logic rd_cycle;

    assign wr_cycle = burst_active_i &  burst_wr_i;
    assign rd_cycle = burst_active_i & ~burst_wr_i;

    // Write side: same-cycle byte-enable suppression, data unchanged
    assign wr_be_o   = {LANES{wr_cycle}} & ~lane_mask_i;
    assign wr_data_o = wr_data_i;

    bmask_rd_pipe #(
        .LANES (LANES)
    ) u_rd_pipe (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .capture_i (rd_cycle),
        .mask_i    (lane_mask_i),
        .oe_o      (rd_oe_o)
    );

    bmask_rd_drive #(
        .LANES    (LANES),
        .LANE_W   (LANE_W),
        .HIZ_MODE (HIZ_MODE)
    ) u_rd_drive (
        .rd_data_i (rd_data_i),
        .oe_i      (rd_oe_o),
        .rd_data_o (rd_data_o),
        .vld_n_o   (rd_vld_n_o)
    );

    bmask_col_ctr #(
        .COL_W     (COL_W),
        .BURST_LEN (BURST_LEN)
    ) u_col_ctr (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (burst_start_i),
        .load_col_i (start_col_i),
        .step_i     (burst_active_i),
        .col_o      (col_addr_o)
    );

endmodule

// File: rtl/bmask_unit_chk.sv
module bmask_unit_chk #(
    parameter int LANES     = 4,
    parameter int LANE_W    = 8,
    parameter int COL_W     = 9,
    parameter int BURST_LEN = 8,
    parameter bit ZERO_FILL = 1'b1,
    localparam int DATA_W   = LANES * LANE_W
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              burst_active_i,
    input logic              burst_wr_i,
    input logic              burst_start_i,
    input logic [COL_W-1:0]  start_col_i,
    input logic [LANES-1:0]  lane_mask_i,
    input logic [DATA_W-1:0] wr_data_i,
    input logic [DATA_W-1:0] rd_data_i,
    input logic [DATA_W-1:0] wr_data_o,
    input logic [LANES-1:0]  wr_be_o,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [LANES-1:0]  rd_oe_o,
    input logic [LANES-1:0]  rd_vld_n_o,
    input logic [COL_W-1:0]  col_addr_o
);

    localparam logic [COL_W-1:0] WIN = COL_W'(BURST_LEN - 1);

    logic [1:0]        since_rst;
    logic [LANES-1:0]  rd_req_mask;
    logic [DATA_W-1:0] off_bits;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            since_rst <= '0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assign rd_req_mask = (burst_active_i && !burst_wr_i) ? lane_mask_i : '0;

    always_comb begin
        for (int i = 0; i < DATA_W; i++) begin
            off_bits[i] = ~rd_oe_o[i / LANE_W];
        end
    end

    // R2: a byte-enable only appears in write cycles, never on a masked lane
    a_r2_be_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|wr_be_o) |-> (burst_active_i && burst_wr_i && ((wr_be_o & lane_mask_i) == '0)));

    // R3: write data polarity kept
    a_r3_wr_data_same: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_data_o == wr_data_i);

    // R4, R5: output enable reflects the read mask sampled two edges earlier
    a_r4_rd_delay: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst >= 2'd2) |-> (rd_oe_o == ~$past(rd_req_mask, 2)));

    // R6: disabled lanes output zero in zero-fill mode
    a_r6_zero_fill: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ZERO_FILL |-> ((rd_data_o & off_bits) == '0));

    // R7: valid-low flag is the complement of drive enable
    a_r7_vld_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rd_vld_n_o == ~rd_oe_o);

    // R8: load takes the start column
    a_r8_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
        burst_start_i |=> (col_addr_o == $past(start_col_i)));

    // R8: step wraps within the window and keeps the upper bits
    a_r8_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (burst_active_i && !burst_start_i) |=>
        (((col_addr_o & ~WIN) == ($past(col_addr_o) & ~WIN)) &&
         ((col_addr_o & WIN) == (($past(col_addr_o) + COL_W'(1)) & WIN))));

    // R9: first cycle after reset release is unmasked with column zero
    a_r9_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (since_rst == 2'd0) |-> ((rd_oe_o == '1) && (col_addr_o == '0)));

endmodule

bind bmask_unit bmask_unit_chk #(
    .LANES     (LANES),
    .LANE_W    (LANE_W),
    .COL_W     (COL_W),
    .BURST_LEN (BURST_LEN),
    .ZERO_FILL (HIZ_MODE == bmask_pkg::MASK_ZERO)
) u_chk (.*);

// File: tb/bmask_unit_tb_top.sv
module bmask_unit_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        burst_active_i = 1'b0;
    logic        burst_wr_i = 1'b0;
    logic        burst_start_i = 1'b0;
    logic [8:0]  start_col_i = '0;
    logic [3:0]  lane_mask_i = '0;
    logic [31:0] wr_data_i = '0;
    logic [31:0] rd_data_i = '0;
    logic [31:0] wr_data_o;
    logic [3:0]  wr_be_o;
    logic [31:0] rd_data_o;
    logic [3:0]  rd_oe_o;
    logic [3:0]  rd_vld_n_o;
    logic [8:0]  col_addr_o;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk_i = ~clk_i;

    bmask_unit dut_i (.*);

    // {active, write, mask[3:0], expected be[3:0]}
    localparam logic [9:0] VEC [8] = '{
        {1'b1, 1'b1, 4'b0000, 4'b1111},
        {1'b1, 1'b1, 4'b0001, 4'b1110},
        {1'b1, 1'b1, 4'b1010, 4'b0101},
        {1'b1, 1'b1, 4'b1111, 4'b0000},
        {1'b1, 1'b0, 4'b0000, 4'b0000},
        {1'b0, 1'b1, 4'b0000, 4'b0000},
        {1'b1, 1'b1, 4'b0110, 4'b1001},
        {1'b1, 1'b1, 4'b1000, 4'b0111}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic fall();
        @(negedge clk_i);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R9: state during reset
        fall();
        burst_active_i = 1'b1;
        lane_mask_i = 4'b1111;
        #1;
        chk("R9 oe in reset", 32'(rd_oe_o), 32'hF);
        chk("R9 col in reset", 32'(col_addr_o), 32'h0);
        fall();
        rst_ni = 1'b1;
        burst_active_i = 1'b0;
        lane_mask_i = '0;
        fall();

        // R2, R3: vector table for the write path
        foreach (VEC[i]) begin
            burst_active_i = VEC[i][9];
            burst_wr_i     = VEC[i][8];
            lane_mask_i    = VEC[i][7:4];
            wr_data_i      = 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101);
            #1;
            chk("R2 write byte-enable", 32'(wr_be_o), 32'(VEC[i][3:0]));
            chk("R3 write data", wr_data_o, 32'h1357_9BDF ^ (32'(i) * 32'h0101_0101));
            fall();
        end
        burst_active_i = 1'b0;
        lane_mask_i = '0;
        fall();
        fall();

        // R4, R1, R6, R7: read mask, lanes 0 and 2
        rd_data_i = 32'hA1B2_C3D4;
        burst_active_i = 1'b1;
        burst_wr_i = 1'b0;
        lane_mask_i = 4'b0101;
        fall();
        lane_mask_i = 4'b0000;
        #1;
        chk("R4 oe one cycle early", 32'(rd_oe_o), 32'hF);
        fall();
        #1;
        chk("R4 oe delayed", 32'(rd_oe_o), 32'hA);
        chk("R1 R6 gated read data", rd_data_o, 32'hA100_C300);
        chk("R7 valid-low", 32'(rd_vld_n_o), 32'h5);
        fall();
        #1;
        chk("R4 oe single cycle", 32'(rd_oe_o), 32'hF);
        chk("R6 unmasked pass", rd_data_o, 32'hA1B2_C3D4);

        // R1: top lane only
        lane_mask_i = 4'b1000;
        fall();
        lane_mask_i = 4'b0000;
        fall();
        #1;
        chk("R1 lane 3 bits 31:24", rd_data_o, 32'h00B2_C3D4);
        chk("R7 lane 3 flag", 32'(rd_vld_n_o), 32'h8);
        fall();

        // R5: write-cycle and idle masks are ignored by the read side
        burst_wr_i = 1'b1;
        lane_mask_i = 4'b1111;
        fall();
        burst_active_i = 1'b0;
        fall();
        #1;
        chk("R5 write mask ignored", 32'(rd_oe_o), 32'hF);
        fall();
        #1;
        chk("R5 idle mask ignored", 32'(rd_oe_o), 32'hF);
        chk("R5 read data intact", rd_data_o, 32'hA1B2_C3D4);
        lane_mask_i = '0;
        burst_wr_i = 1'b0;
        fall();

        // R8: load, step through masked cycles, wrap, hold
        burst_start_i = 1'b1;
        start_col_i = 9'h1F6;
        fall();
        #1;
        chk("R8 load", 32'(col_addr_o), 32'h1F6);
        burst_start_i = 1'b0;
        burst_active_i = 1'b1;
        lane_mask_i = 4'b1111;
        fall();
        #1;
        chk("R8 step masked", 32'(col_addr_o), 32'h1F7);
        fall();
        #1;
        chk("R8 wrap", 32'(col_addr_o), 32'h1F0);
        fall();
        #1;
        chk("R8 after wrap", 32'(col_addr_o), 32'h1F1);
        burst_active_i = 1'b0;
        lane_mask_i = '0;
        fall();
        #1;
        chk("R8 hold when idle", 32'(col_addr_o), 32'h1F1);
        fall();

        // R9: reset in the middle of a masked read clears the pipeline
        burst_active_i = 1'b1;
        lane_mask_i = 4'b1111;
        fall();
        rst_ni = 1'b0;
        #1;
        chk("R9 oe cleared by reset", 32'(rd_oe_o), 32'hF);
        chk("R9 col cleared by reset", 32'(col_addr_o), 32'h0);
        fall();
        rst_ni = 1'b1;
        burst_active_i = 1'b0;
        lane_mask_i = '0;
        fall();
        #1;
        chk("R9 oe after release", 32'(rd_oe_o), 32'hF);
        fall();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule